// File: doc/BRIEF.md
# Two-Level Branch Target Buffer

This block predicts branches at fetch time. It is a four-way set-associative buffer of 128 sets. Each way holds a branch's tag, a small type code, its 32-bit target, a 4-bit record of that branch's recent outcomes and a stored prediction bit. Each set also owns three bits of tree pseudo-LRU state and a table of sixteen 2-bit saturating counters. All four ways of the set share that table. On a lookup, the hitting way's outcome record picks one counter of its set's table. The counter's upper bit is the taken prediction, and the way supplies the target and type.

The fetch stage presents an address on the lookup port and reads the prediction in the same cycle, because the lookup is combinational over the stored state. When the branch resolves, the pipeline presents the branch address, its outcome, its target and its type on the update port. On a hit, the update trains the selected counter, shifts the outcome into the way's record and rewrites the way's target and type. On a miss with a taken outcome, the update allocates a way. A miss with a not-taken outcome leaves the buffer alone.

Top module: `btb_local_hist`

## Requirements
- R1: A lookup hits only when a valid way of the set selected by address bits [10:4] holds the tag equal to address bits [19:11]. On a miss, the hit and taken outputs are 0.
- R2: On a hit, the taken output is bit 1 of the set's counter indexed by the hitting way's 4-bit history. The target and type outputs come from that way.
- R3: An update that hits moves the selected counter up on taken and down on not-taken, saturating at 3 and at 0.
- R4: An update that hits shifts the outcome (1 = taken) into history bit 0 and drops history bit 3.
- R5: After an update, the way's stored prediction bit, visible on the hint output during a hit, equals bit 1 of the counter just written or, on allocation, bit 1 of counter 0.
- R6: A taken update that misses allocates the lowest-numbered invalid way of the set. The new way gets the update's tag, target and type, its history is cleared and no counter changes. A not-taken update that misses allocates nothing.
- R7: When no way of the set is invalid, allocation replaces the way chosen by a 3-bit tree pseudo-LRU. Every update that hits or allocates marks its way as most recent. With ways 0, 1, 2, 3 touched in that order, way 0 is the one replaced.
- R8: The four ways of a set share one counter table, and each set's table is separate from every other set's.
- R9: An update that hits overwrites the way's target and type with the update's values.
- R10: A lookup in the same cycle as an update to the same set sees the state before the update. The update is visible from the next cycle on.
- R11: After reset every way is invalid, every counter holds 1 (weakly not taken) and every replacement state is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lu_addr | input | 32 | Fetch address looked up |
| lu_hit | output | 1 | A valid way matches the lookup |
| lu_taken | output | 1 | Taken prediction from the shared counter |
| lu_target | output | 32 | Predicted target (0 on a miss) |
| lu_type | output | 2 | Stored branch type code |
| lu_hint | output | 1 | Stored per-way prediction bit |
| upd_valid | input | 1 | Resolved branch presented this cycle |
| upd_addr | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Outcome, 1 = taken |
| upd_target | input | 32 | Resolved target |
| upd_type | input | 2 | Branch type code to store |

## Verification
One branch is trained first with a run of taken outcomes and then with a run of not-taken outcomes. During the first run, predictions stay not-taken until a repeated history reaches an already trained counter. That tells history indexing apart from a single per-branch counter, and it shows the oldest bit being dropped. The runs continue past both counter limits, and the stored hint is read where it differs from the live counter. Further updates fill one set with five distinct tags, which shows free-way allocation, pseudo-LRU replacement and counter sharing between ways. A second set shows that the tables are independent, and a lookup in the same cycle as an update shows that the lookup returns the old values.

// File: rtl/btb_pkg.sv
package btb_pkg;
    localparam int ADDR_W    = 32;
    localparam int IDX_LSB   = 4;
    localparam int SET_BITS  = 7;
    localparam int TAG_BITS  = 9;
    localparam int HIST_BITS = 4;
    localparam int TYPE_W    = 2;
    localparam int WAYS      = 4;   // tree replacement below is built for four ways

    localparam int SETS    = 1 << SET_BITS;
    localparam int PHT_N   = 1 << HIST_BITS;
    localparam int WAY_W   = $clog2(WAYS);
    localparam int TAG_LSB = IDX_LSB + SET_BITS;
    localparam int TAG_MSB = TAG_LSB + TAG_BITS - 1;
    localparam int PLRU_W  = WAYS - 1;

    typedef struct packed {
        logic [TAG_BITS-1:0]  tag;
        logic [TYPE_W-1:0]    kind;
        logic [ADDR_W-1:0]    target;
        logic [HIST_BITS-1:0] hist;
        logic                 pred;
    } way_t;

    typedef struct packed {
        logic                 way_en;
        logic [SET_BITS-1:0]  set;
        logic [WAY_W-1:0]     way;
        way_t                 ent;
        logic                 ctr_en;
        logic [HIST_BITS-1:0] ctr_idx;
        logic [1:0]           ctr;
        logic [PLRU_W-1:0]    plru;
    } wr_t;

    function automatic logic [1:0] ctr_train(input logic [1:0] c, input logic up);
        if (up)  return (c == 2'b11) ? c : c + 2'b01;
        else     return (c == 2'b00) ? c : c - 2'b01;
    endfunction

    // bit 0 picks the pair holding the older way (0 = ways 0/1), bit 1 and bit 2 pick inside a pair
    function automatic logic [WAY_W-1:0] plru_victim(input logic [PLRU_W-1:0] s);
        if (!s[0]) return s[1] ? WAY_W'(1) : WAY_W'(0);
        else       return s[2] ? WAY_W'(3) : WAY_W'(2);
    endfunction
endpackage

// File: rtl/btb_way_match.sv
module btb_way_match
    import btb_pkg::*;
(
    input  logic [WAYS-1:0]                valid_i,
    input  logic [WAYS-1:0][TAG_BITS-1:0]  tags_i,
    input  logic [TAG_BITS-1:0]            tag_i,
    output logic [WAYS-1:0]                hit_vec_o,
    output logic                           hit_o,
    output logic [WAY_W-1:0]               way_o
);
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign hit_vec_o[g] = valid_i[g] && (tags_i[g] == tag_i);
    end

    always_comb begin
        way_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec_o[w]) way_o = WAY_W'(w);
        end
    end

    assign hit_o = |hit_vec_o;
endmodule

// File: rtl/btb_plru_tree.sv
module btb_plru_tree
    import btb_pkg::*;
(
    input  logic [PLRU_W-1:0] state_i,
    input  logic [WAY_W-1:0]  touch_i,
    output logic [WAY_W-1:0]  victim_o,
    output logic [PLRU_W-1:0] state_o
);
    assign victim_o = plru_victim(state_i);

    always_comb begin
        state_o = state_i;
        if (!touch_i[1]) begin
            state_o[0] = 1'b1;          // older pair is now ways 2/3
            state_o[1] = ~touch_i[0];
        end else begin
            state_o[0] = 1'b0;
            state_o[2] = ~touch_i[0];
        end
    end
endmodule

// File: rtl/btb_local_hist.sv
module btb_local_hist
    import btb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       lu_addr,
    output logic              lu_hit,
    output logic              lu_taken,
    output logic [31:0]       lu_target,
    output logic [1:0]        lu_type,
    output logic              lu_hint,
    input  logic              upd_valid,
    input  logic [31:0]       upd_addr,
    input  logic              upd_taken,
    input  logic [31:0]       upd_target,
    input  logic [1:0]        upd_type
);
    // stored state
    logic              valid_q [SETS][WAYS];
    way_t              ent_q   [SETS][WAYS];
    logic [1:0]        pht_q   [SETS][PHT_N];
    logic [PLRU_W-1:0] plru_q  [SETS];

    // lookup side
    logic [SET_BITS-1:0]               lu_set;
    logic [TAG_BITS-1:0]               lu_tag;
    logic [WAYS-1:0]                   lu_vld_v, lu_hit_vec;
    logic [WAYS-1:0][TAG_BITS-1:0]     lu_tags;
    logic [WAY_W-1:0]                  lu_way;
    way_t                              lu_ent;

    assign lu_set = lu_addr[TAG_LSB-1:IDX_LSB];
    assign lu_tag = lu_addr[TAG_MSB:TAG_LSB];

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            lu_vld_v[w] = valid_q[lu_set][w];
            lu_tags[w]  = ent_q[lu_set][w].tag;
        end
    end

    btb_way_match u_lu_match (
        .valid_i(lu_vld_v), .tags_i(lu_tags), .tag_i(lu_tag),
        .hit_vec_o(lu_hit_vec), .hit_o(lu_hit), .way_o(lu_way)
    );

    assign lu_ent    = ent_q[lu_set][lu_way];
    assign lu_taken  = lu_hit && pht_q[lu_set][lu_ent.hist][1];
    assign lu_target = lu_hit ? lu_ent.target : '0;
    assign lu_type   = lu_hit ? lu_ent.kind : '0;
    assign lu_hint   = lu_hit && lu_ent.pred;

    // update side
    logic [SET_BITS-1:0]               up_set;
    logic [TAG_BITS-1:0]               up_tag;
    logic [WAYS-1:0]                   up_vld_v, up_hit_vec;
    logic [WAYS-1:0][TAG_BITS-1:0]     up_tags;
    logic [WAY_W-1:0]                  up_way, up_victim, free_way, alloc_way;
    logic                              up_hit, has_free;
    way_t                              up_old;
    logic [1:0]                        up_ctr_new;
    logic [PLRU_W-1:0]                 plru_next;
    wr_t                               wr_d;

    assign up_set = upd_addr[TAG_LSB-1:IDX_LSB];
    assign up_tag = upd_addr[TAG_MSB:TAG_LSB];

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            up_vld_v[w] = valid_q[up_set][w];
            up_tags[w]  = ent_q[up_set][w].tag;
        end
        has_free = 1'b0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!up_vld_v[w]) begin
                has_free = 1'b1;
                free_way = WAY_W'(w);
            end
        end
    end

    btb_way_match u_up_match (
        .valid_i(up_vld_v), .tags_i(up_tags), .tag_i(up_tag),
        .hit_vec_o(up_hit_vec), .hit_o(up_hit), .way_o(up_way)
    );

    assign alloc_way  = has_free ? free_way : up_victim;
    assign up_old     = ent_q[up_set][up_way];
    assign up_ctr_new = ctr_train(pht_q[up_set][up_old.hist], upd_taken);

    btb_plru_tree u_plru (
        .state_i(plru_q[up_set]), .touch_i(wr_d.way),
        .victim_o(up_victim), .state_o(plru_next)
    );

    always_comb begin
        wr_d         = '0;
        wr_d.set     = up_set;
        wr_d.ctr_idx = up_old.hist;
        wr_d.ctr     = up_ctr_new;
        if (upd_valid && up_hit) begin
            wr_d.way_en = 1'b1;
            wr_d.way    = up_way;
            wr_d.ctr_en = 1'b1;
            wr_d.ent    = '{tag: up_old.tag, kind: upd_type, target: upd_target,
                            hist: {up_old.hist[HIST_BITS-2:0], upd_taken},
                            pred: up_ctr_new[1]};
        end else if (upd_valid && upd_taken) begin
            wr_d.way_en = 1'b1;
            wr_d.way    = alloc_way;
            wr_d.ent    = '{tag: up_tag, kind: upd_type, target: upd_target,
                            hist: '0, pred: pht_q[up_set][0][1]};
        end
        wr_d.plru = plru_next;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                plru_q[s] <= '0;
                for (int w = 0; w < WAYS; w++)  valid_q[s][w] <= 1'b0;
                for (int c = 0; c < PHT_N; c++) pht_q[s][c]   <= 2'b01;
            end
        end else begin
            if (wr_d.way_en) begin
                valid_q[wr_d.set][wr_d.way] <= 1'b1;
                plru_q[wr_d.set]            <= wr_d.plru;
            end
            if (wr_d.ctr_en) pht_q[wr_d.set][wr_d.ctr_idx] <= wr_d.ctr;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_d.way_en) ent_q[wr_d.set][wr_d.way] <= wr_d.ent;
    end

    logic unused_bits;
    assign unused_bits = ^{lu_addr[31:TAG_MSB+1], lu_addr[IDX_LSB-1:0],
                           upd_addr[31:TAG_MSB+1], upd_addr[IDX_LSB-1:0],
                           up_hit_vec, lu_hit_vec};

    // R1: at most one way of a set answers a tag
    p_single_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lu_hit_vec));

    // R3: a counter at a limit stays there when pushed past it
    p_ctr_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && up_hit &&
         pht_q[up_set][up_old.hist] == {upd_taken, upd_taken})
        |=> pht_q[$past(up_set)][$past(up_old.hist)] == {$past(upd_taken), $past(upd_taken)});

    // R5: stored hint follows the counter that was trained
    p_hint_msb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && up_hit)
        |=> ent_q[$past(up_set)][$past(up_way)].pred == pht_q[$past(up_set)][$past(up_old.hist)][1]);

    // R6: a freshly allocated way is valid with empty history
    p_alloc_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !up_hit && upd_taken)
        |=> valid_q[$past(up_set)][$past(alloc_way)] &&
            ent_q[$past(up_set)][$past(alloc_way)].hist == '0);

    // R7: the way just touched is never the next victim
    p_victim_fresh_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_d.way_en |=> plru_victim(plru_q[$past(wr_d.set)]) != $past(wr_d.way));
endmodule

// File: tb/btb_local_hist_test.sv
`timescale 1ns/1ps
module btb_local_hist_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lu_addr = '0;
    logic        lu_hit, lu_taken, lu_hint;
    logic [31:0] lu_target;
    logic [1:0]  lu_type;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_addr = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;
    logic [1:0]  upd_type = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    btb_local_hist uut (
        .clk(clk), .rst_n(rst_n), .lu_addr(lu_addr), .lu_hit(lu_hit),
        .lu_taken(lu_taken), .lu_target(lu_target), .lu_type(lu_type),
        .lu_hint(lu_hint), .upd_valid(upd_valid), .upd_addr(upd_addr),
        .upd_taken(upd_taken), .upd_target(upd_target), .upd_type(upd_type)
    );

    // set 5 with tags 1..5, and set 6 with tag 1
    localparam logic [31:0] A  = 32'h0000_0850;
    localparam logic [31:0] B  = 32'h0000_1050;
    localparam logic [31:0] C2 = 32'h0000_1850;
    localparam logic [31:0] D  = 32'h0000_2050;
    localparam logic [31:0] E  = 32'h0000_2850;
    localparam logic [31:0] C  = 32'h0000_0860;
    localparam logic [31:0] T1 = 32'h1000, T2 = 32'h2000, T3 = 32'h3000;
    localparam logic [31:0] T4 = 32'h4000, T5 = 32'h5000, T6 = 32'h6000;
    localparam logic [31:0] T7 = 32'h7000;

    typedef struct packed {
        logic [7:0]  req;
        logic        u_en;
        logic [31:0] u_addr;
        logic        u_tk;
        logic [31:0] u_tgt;
        logic [1:0]  u_ty;
        logic [31:0] l_addr;
        logic        e_hit;
        logic        e_tk;
        logic [31:0] e_tgt;
        logic [1:0]  e_ty;
        logic        e_hint;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VEC [NV] = '{
        '{8'd1,  1'b0, A,  1'b0, T1, 2'd0, A,  1'b0, 1'b0, T1, 2'd0, 1'b0}, // R1 empty
        '{8'd6,  1'b1, A,  1'b0, T1, 2'd1, A,  1'b0, 1'b0, T1, 2'd0, 1'b0}, // R6 not-taken miss
        '{8'd6,  1'b1, A,  1'b1, T1, 2'd1, A,  1'b1, 1'b0, T1, 2'd1, 1'b0}, // R6 allocate way 0
        '{8'd3,  1'b1, A,  1'b1, T1, 2'd1, A,  1'b1, 1'b0, T1, 2'd1, 1'b1}, // R3 ctr0 -> 2, hist 1
        '{8'd4,  1'b1, A,  1'b1, T1, 2'd1, A,  1'b1, 1'b0, T1, 2'd1, 1'b1}, // R4 hist 3
        '{8'd4,  1'b1, A,  1'b1, T1, 2'd1, A,  1'b1, 1'b0, T1, 2'd1, 1'b1}, // R4 hist 7
        '{8'd4,  1'b1, A,  1'b1, T1, 2'd1, A,  1'b1, 1'b0, T1, 2'd1, 1'b1}, // R4 hist 15
        '{8'd4,  1'b1, A,  1'b1, T1, 2'd1, A,  1'b1, 1'b1, T1, 2'd1, 1'b1}, // R4 oldest dropped, ctr15=2
        '{8'd3,  1'b1, A,  1'b1, T1, 2'd1, A,  1'b1, 1'b1, T1, 2'd1, 1'b1}, // R3 ctr15=3
        '{8'd3,  1'b1, A,  1'b1, T1, 2'd1, A,  1'b1, 1'b1, T1, 2'd1, 1'b1}, // R3 saturate at 3
        '{8'd5,  1'b1, A,  1'b0, T1, 2'd1, A,  1'b1, 1'b0, T1, 2'd1, 1'b1}, // R5 hint 1, idx14 says 0
        '{8'd4,  1'b1, A,  1'b0, T1, 2'd1, A,  1'b1, 1'b0, T1, 2'd1, 1'b0}, // R4 hist 12
        '{8'd4,  1'b1, A,  1'b0, T1, 2'd1, A,  1'b1, 1'b0, T1, 2'd1, 1'b0}, // R4 hist 8
        '{8'd2,  1'b1, A,  1'b0, T1, 2'd1, A,  1'b1, 1'b1, T1, 2'd1, 1'b0}, // R2 hist 0 -> ctr0=2
        '{8'd3,  1'b1, A,  1'b0, T1, 2'd1, A,  1'b1, 1'b0, T1, 2'd1, 1'b0}, // R3 ctr0=1
        '{8'd3,  1'b1, A,  1'b0, T1, 2'd1, A,  1'b1, 1'b0, T1, 2'd1, 1'b0}, // R3 ctr0=0
        '{8'd3,  1'b1, A,  1'b0, T1, 2'd1, A,  1'b1, 1'b0, T1, 2'd1, 1'b0}, // R3 saturate at 0
        '{8'd9,  1'b1, A,  1'b1, T2, 2'd2, A,  1'b1, 1'b1, T2, 2'd2, 1'b0}, // R9 new target/type, R3 hint 0
        '{8'd6,  1'b1, B,  1'b1, T3, 2'd3, B,  1'b1, 1'b0, T3, 2'd3, 1'b0}, // R6 way 1
        '{8'd8,  1'b1, B,  1'b1, T3, 2'd3, B,  1'b1, 1'b1, T3, 2'd3, 1'b1}, // R8 B reads ctr1 trained by A
        '{8'd8,  1'b0, A,  1'b0, T1, 2'd0, C,  1'b0, 1'b0, T1, 2'd0, 1'b0}, // R8 other set empty
        '{8'd6,  1'b1, C2, 1'b1, T4, 2'd0, C2, 1'b1, 1'b1, T4, 2'd0, 1'b1}, // R6 way 2
        '{8'd6,  1'b1, D,  1'b1, T5, 2'd1, D,  1'b1, 1'b1, T5, 2'd1, 1'b1}, // R6 way 3
        '{8'd7,  1'b1, E,  1'b1, T6, 2'd2, E,  1'b1, 1'b1, T6, 2'd2, 1'b1}, // R7 replaces way 0
        '{8'd7,  1'b0, A,  1'b0, T1, 2'd0, A,  1'b0, 1'b0, T1, 2'd0, 1'b0}, // R7 A gone
        '{8'd7,  1'b0, A,  1'b0, T1, 2'd0, B,  1'b1, 1'b1, T3, 2'd3, 1'b1}, // R7 B kept
        '{8'd8,  1'b1, C,  1'b1, T1, 2'd0, C,  1'b1, 1'b0, T1, 2'd0, 1'b0}  // R8 set 6 ctr0 still 1
    };

    task automatic chk(input string req, input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        upd_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R11: empty after reset
        lu_addr = A;
        #1;
        chk("R11", lu_hit == 1'b0, "hit after reset", 32'(lu_hit), 32'd0);
        chk("R11", lu_taken == 1'b0, "taken after reset", 32'(lu_taken), 32'd0);

        for (int i = 0; i < NV; i++) begin
            string rq;
            @(negedge clk);
            rq = $sformatf("R%0d", VEC[i].req);
            upd_valid  = VEC[i].u_en;
            upd_addr   = VEC[i].u_addr;
            upd_taken  = VEC[i].u_tk;
            upd_target = VEC[i].u_tgt;
            upd_type   = VEC[i].u_ty;
            lu_addr    = VEC[i].l_addr;
            @(posedge clk);
            #1;
            upd_valid = 1'b0;
            #1;
            chk(rq, lu_hit == VEC[i].e_hit, $sformatf("row %0d hit", i),
                32'(lu_hit), 32'(VEC[i].e_hit));
            if (VEC[i].e_hit) begin
                chk(rq, lu_taken == VEC[i].e_tk, $sformatf("row %0d taken", i),
                    32'(lu_taken), 32'(VEC[i].e_tk));
                chk(rq, lu_target == VEC[i].e_tgt, $sformatf("row %0d target", i),
                    lu_target, VEC[i].e_tgt);
                chk(rq, lu_type == VEC[i].e_ty, $sformatf("row %0d type", i),
                    32'(lu_type), 32'(VEC[i].e_ty));
                chk(rq, lu_hint == VEC[i].e_hint, $sformatf("row %0d hint", i),
                    32'(lu_hint), 32'(VEC[i].e_hint));
            end else begin
                chk(rq, lu_taken == 1'b0, $sformatf("row %0d miss taken", i),
                    32'(lu_taken), 32'd0);
            end
        end

        // R10: lookup during an update of the same way returns the old values
        @(negedge clk);
        upd_valid = 1'b1; upd_addr = B; upd_taken = 1'b1; upd_target = T7; upd_type = 2'd1;
        lu_addr = B;
        #1;
        chk("R10", lu_target == T3, "same-cycle target", lu_target, T3);
        chk("R10", lu_type == 2'd3, "same-cycle type", 32'(lu_type), 32'd3);
        @(posedge clk);
        #1;
        upd_valid = 1'b0;
        #1;
        chk("R10", lu_target == T7, "next-cycle target", lu_target, T7);
        chk("R10", lu_type == 2'd1, "next-cycle type", 32'(lu_type), 32'd1);

        // R11: a second reset empties the buffer again
        do_reset();
        lu_addr = B;
        #1;
        chk("R11", lu_hit == 1'b0, "B after reset", 32'(lu_hit), 32'd0);
        lu_addr = E;
        #1;
        chk("R11", lu_hit == 1'b0, "E after reset", 32'(lu_hit), 32'd0);
        // R11: counter 0 back at weakly not taken after a fresh allocation
        @(negedge clk);
        upd_valid = 1'b1; upd_addr = E; upd_taken = 1'b1; upd_target = T6; upd_type = 2'd2;
        @(posedge clk);
        #1;
        upd_valid = 1'b0;
        #1;
        chk("R11", lu_hit == 1'b1 && lu_taken == 1'b0, "counter reset value",
            {lu_hit, lu_taken}, 32'h2);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule